// File: doc/BRIEF.md
# Dual-Half Prescaled Waveform Timer

This block is a pair of 8-bit counters. They run either as two separate halves or chained into one longer timer, and they drive two waveform pins, one per half. Each half counts ticks from its own 8-bit prescaler. A half can also count rising edges of an external event input. Each half rolls over when its count reaches a programmed period. At that point it can invert a square-wave output, or it can serve as the time base of a pulse-width modulated output whose high time follows a duty value.

A 2-bit mode field picks one of four uses:
- two toggle timers;
- two PWM channels;
- a chained timer, where the low half toggles at its own rollover and the high half toggles at the chained rollover;
- a chained timer whose low half produces PWM while the high half toggles.

Software loads mode, prescaler limits, periods and duty values through a simple write port. New period and duty values wait in shadow registers and reach the counter only at that half's next rollover. This keeps every PWM period whole.

Top module: `dual_tmr_wave`

## Requirements
- R1: While reset is high, both waveform outputs and both match flags are low. Reset clears every counter, prescaler and register, so after reset the block is in mode 0 with a prescaler limit of 0 and a period of 0, and the low waveform inverts on every clock.
- R2: A write with `wr_en` high stores `wr_data` into the register chosen by `wr_addr`: 0 = control (bits 1:0 mode, bit 2 event select), 1 = low prescaler limit, 2 = high prescaler limit, 3 = low period, 4 = high period, 5 = low duty, 6 = high duty. A write to address 7 changes nothing.
- R3: A prescaler with limit P gives one tick every P+1 clocks.
- R4: In mode 0 each half counts from 0 up to its period N and rolls over. Its waveform inverts once every (P+1)(N+1) clocks. Its match flag is a one-clock pulse in the same clock as that inversion.
- R5: In mode 0 with event select set, the high half advances on each rising edge of `ev_in`, and its prescaler has no effect.
- R6: In mode 1 both halves are PWM. With prescaler P, period N and duty D ≤ N+1, the output is high for D(P+1) clocks of every (N+1)(P+1).
- R7: In a PWM half, a duty of 0 holds the output low. A duty larger than the period holds it high.
- R8: In mode 2 the high half advances once per low-half rollover. The low waveform inverts every (Plo+1)(Nlo+1) clocks and the high waveform every (Plo+1)(Nlo+1)(Nhi+1) clocks. The high prescaler has no effect.
- R9: In mode 3 the halves are chained as in mode 2, but the low half is PWM, per R6, and the high waveform toggles.
- R10: Period and duty writes take effect at the half's next rollover. The interval or high time already in progress keeps the old value.
- R11: In mode 2 with event select set, the low half advances on each rising edge of `ev_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 8 | Write data |
| ev_in | input | 1 | External event input, synchronous to clk |
| wave_lo | output | 1 | Low-half waveform |
| wave_hi | output | 1 | High-half waveform |
| match_lo | output | 1 | One-clock pulse on low-half rollover |
| match_hi | output | 1 | One-clock pulse on high-half rollover |

## Verification
Several kinds of internal fault show up directly at the pins:
- A prescaler or counter stuck or off by one stretches or shrinks the interval between waveform edges. This is visible within one output period.
- An active period or duty register loaded at the wrong moment breaks the whole-period guarantee. The high time in progress, or the interval in progress, then takes the new value one period early.
- A wrong chaining source in modes 2 and 3 puts the high waveform off its expected multiple of the low period within one high period.
- A stale toggle register leaves edges and match pulses out of step in the very next clock.

// File: rtl/dtw_pkg.sv
package dtw_pkg;

    localparam int CNT_W  = 8;
    localparam int PSC_W  = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        MD_SPLIT     = 2'd0,
        MD_DUAL_PWM  = 2'd1,
        MD_CHAIN     = 2'd2,
        MD_CHAIN_PWM = 2'd3
    } tmr_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL    = 3'd0,
        RA_PSC_LO  = 3'd1,
        RA_PSC_HI  = 3'd2,
        RA_PER_LO  = 3'd3,
        RA_PER_HI  = 3'd4,
        RA_DUTY_LO = 3'd5,
        RA_DUTY_HI = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic      ev_sel;
        tmr_mode_e mode;
    } ctrl_t;

    // half 0 = low byte, half 1 = high byte
    function automatic logic half_is_pwm(tmr_mode_e m, int unsigned h);
        if (h == 0) return (m == MD_DUAL_PWM) || (m == MD_CHAIN_PWM);
        return m == MD_DUAL_PWM;
    endfunction

    function automatic logic is_chained(tmr_mode_e m);
        return (m == MD_CHAIN) || (m == MD_CHAIN_PWM);
    endfunction

    function automatic logic half_on_event(ctrl_t c, int unsigned h);
        if (!c.ev_sel) return 1'b0;
        if (h == 1) return c.mode == MD_SPLIT;
        return c.mode == MD_CHAIN;
    endfunction

endpackage

// File: rtl/dtw_prescaler.sv
module dtw_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lim,
    output logic         tick
);
    logic [W-1:0] pc;

    // >= rather than == so a shrinking limit never strands the count
    assign tick = (pc >= lim);

    always_ff @(posedge clk) begin
        if (rst)       pc <= '0;
        else if (tick) pc <= '0;
        else           pc <= pc + 1'b1;
    end

    p_psc_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        tick |=> (pc == '0));
    p_psc_step_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> (pc == $past(pc) + 1'b1));
endmodule

// File: rtl/dtw_half.sv
module dtw_half #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] per_sh,
    input  logic [W-1:0] duty_sh,
    output logic [W-1:0] cnt,
    output logic [W-1:0] duty_act,
    output logic         roll
);
    logic [W-1:0] per_act;

    assign roll = tick && (cnt == per_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            per_act  <= '0;
            duty_act <= '0;
        end else if (roll) begin
            cnt      <= '0;
            per_act  <= per_sh;
            duty_act <= duty_sh;
        end else if (tick) begin
            cnt      <= cnt + 1'b1;
        end
    end

    p_roll_clear_r4: assert property (@(posedge clk) disable iff (rst)
        roll |=> (cnt == '0));
    p_cnt_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));
    p_shadow_load_r10: assert property (@(posedge clk) disable iff (rst)
        roll |=> (per_act == $past(per_sh)) && (duty_act == $past(duty_sh)));
    p_active_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !roll |=> $stable(per_act) && $stable(duty_act));
endmodule

// File: rtl/dtw_wave.sv
module dtw_wave #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pwm,
    input  logic         roll,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] duty,
    output logic         wave,
    output logic         flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wave <= 1'b0;
            flag <= 1'b0;
        end else begin
            flag <= roll;
            wave <= pwm ? (cnt < duty) : (wave ^ roll);
        end
    end

    p_duty0_low_r7: assert property (@(posedge clk) disable iff (rst)
        (pwm && duty == '0) |=> !wave);
    p_toggle_flag_r4: assert property (@(posedge clk) disable iff (rst)
        !pwm |=> ((wave != $past(wave)) == flag));
endmodule

// File: rtl/dual_tmr_wave.sv
module dual_tmr_wave
    import dtw_pkg::*;
#(
    parameter int W     = CNT_W,
    parameter int PSC_B = PSC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              ev_in,
    output logic              wave_lo,
    output logic              wave_hi,
    output logic              match_lo,
    output logic              match_hi
);
    localparam int NH = 2;

    ctrl_t            ctrl;
    logic [PSC_B-1:0] psc_q  [NH];
    logic [W-1:0]     per_q  [NH];
    logic [W-1:0]     duty_q [NH];
    logic             ev_q;
    logic             ev_rise;

    logic [NH-1:0]    psc_tick;
    logic [NH-1:0]    tick;
    logic [NH-1:0]    roll;
    logic [NH-1:0]    wave;
    logic [NH-1:0]    flag;
    logic [W-1:0]     cnt      [NH];
    logic [W-1:0]     duty_act [NH];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            ev_q <= 1'b0;
            for (int i = 0; i < NH; i++) begin
                psc_q[i]  <= '0;
                per_q[i]  <= '0;
                duty_q[i] <= '0;
            end
        end else begin
            ev_q <= ev_in;
            if (wr_en) begin
                case (wr_addr)
                    RA_CTRL:    ctrl <= '{ev_sel: wr_data[2],
                                          mode: tmr_mode_e'(wr_data[1:0])};
                    RA_PSC_LO:  psc_q[0]  <= wr_data[PSC_B-1:0];
                    RA_PSC_HI:  psc_q[1]  <= wr_data[PSC_B-1:0];
                    RA_PER_LO:  per_q[0]  <= wr_data;
                    RA_PER_HI:  per_q[1]  <= wr_data;
                    RA_DUTY_LO: duty_q[0] <= wr_data;
                    RA_DUTY_HI: duty_q[1] <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    assign ev_rise = ev_in && !ev_q;

    for (genvar h = 0; h < NH; h++) begin : g_half
        dtw_prescaler #(.W(PSC_B)) u_psc (
            .clk  (clk),
            .rst  (rst),
            .lim  (psc_q[h]),
            .tick (psc_tick[h])
        );

        if (h == 0) begin : g_src_lo
            assign tick[h] = half_on_event(ctrl, h) ? ev_rise : psc_tick[h];
        end else begin : g_src_hi
            assign tick[h] = half_on_event(ctrl, h)  ? ev_rise :
                             is_chained(ctrl.mode)   ? roll[0] : psc_tick[h];
        end

        dtw_half #(.W(W)) u_half (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick[h]),
            .per_sh   (per_q[h]),
            .duty_sh  (duty_q[h]),
            .cnt      (cnt[h]),
            .duty_act (duty_act[h]),
            .roll     (roll[h])
        );

        dtw_wave #(.W(W)) u_wave (
            .clk  (clk),
            .rst  (rst),
            .pwm  (half_is_pwm(ctrl.mode, h)),
            .roll (roll[h]),
            .cnt  (cnt[h]),
            .duty (duty_act[h]),
            .wave (wave[h]),
            .flag (flag[h])
        );
    end

    assign wave_lo  = wave[0];
    assign wave_hi  = wave[1];
    assign match_lo = flag[0];
    assign match_hi = flag[1];

    // R8: in chained modes the high half moves only on a low rollover
    p_chain_step_r8: assert property (@(posedge clk) disable iff (rst)
        (is_chained(ctrl.mode) && !ctrl.ev_sel && !roll[0]) |=> $stable(cnt[1]));
endmodule

// File: tb/sim_dual_tmr_wave.sv
module sim_dual_tmr_wave;

    localparam int LIM = 5000;
    localparam logic [2:0] A_CTRL = 3'd0, A_PSC_LO = 3'd1, A_PSC_HI = 3'd2,
                           A_PER_LO = 3'd3, A_PER_HI = 3'd4,
                           A_DUTY_LO = 3'd5, A_DUTY_HI = 3'd6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ev_in = 1'b0;
    logic       wave_lo, wave_hi, match_lo, match_hi;

    always #4 clk = ~clk;

    dual_tmr_wave u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ev_in(ev_in), .wave_lo(wave_lo),
        .wave_hi(wave_hi), .match_lo(match_lo), .match_hi(match_hi)
    );

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        string req;
        int    exp;
    } exp_t;
    exp_t sb_q[$];

    task automatic push_exp(input string req, input int e);
        exp_t it;
        it.req = req;
        it.exp = e;
        sb_q.push_back(it);
    endtask

    task automatic pop_cmp(input int act);
        exp_t it;
        n_chk++;
        if (sb_q.size() == 0) begin
            n_fail++;
            $display("FAIL scoreboard empty: actual %0d expected an item", act);
        end else begin
            it = sb_q.pop_front();
            if (act != it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %0d expected %0d", it.req, act, it.exp);
            end
        end
    endtask

    function automatic logic sig(input int s);
        case (s)
            0: return wave_lo;
            1: return wave_hi;
            2: return match_lo;
            default: return match_hi;
        endcase
    endfunction

    task automatic wait_level(input int s, input logic lvl, output int n);
        n = 0;
        while (sig(s) !== lvl && n < LIM) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic gap_change(input int s, output int n);
        logic v;
        v = sig(s);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sig(s) === v && n < LIM);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic settle(input int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic toggle_gap(input int s, input string req, input int e);
        int n;
        push_exp(req, e);
        gap_change(s, n);
        gap_change(s, n);
        pop_cmp(n);
    endtask

    task automatic pulse_gap(input int s, input string req, input int e);
        int a, b;
        push_exp(req, e);
        wait_level(s, 1'b1, a);
        wait_level(s, 1'b0, a);
        wait_level(s, 1'b1, b);
        pop_cmp(a + b);
    endtask

    task automatic pwm_meas(input int s, input string req, input int eh, input int ep);
        int a, h, l;
        push_exp({req, " high time"}, eh);
        push_exp({req, " period"}, ep);
        wait_level(s, 1'b0, a);
        wait_level(s, 1'b1, a);
        wait_level(s, 1'b0, h);
        wait_level(s, 1'b1, l);
        pop_cmp(h);
        pop_cmp(h + l);
    endtask

    task automatic const_level(input int s, input string req, input int c, input logic lvl);
        int bad;
        bad = 0;
        push_exp(req, 0);
        for (int i = 0; i < c; i++) begin
            @(negedge clk);
            if (sig(s) !== lvl) bad++;
        end
        pop_cmp(bad);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // event source: a rising edge every 6 clocks
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            ev_in = ~ev_in;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung run expected completion");
        finish_run();
    end

    initial begin
        int n, h, l;

        // R1: outputs low during reset, defaults afterwards
        rst = 1'b1;
        repeat (3) @(negedge clk);
        push_exp("R1 outputs during reset", 0);
        pop_cmp({28'd0, wave_lo, wave_hi, match_lo, match_hi});
        rst = 1'b0;
        toggle_gap(0, "R1 default mode 0 limit 0 period 0", 1);

        // R3 R4: two toggle timers
        do_reset();
        wr(A_PSC_LO, 8'd2);
        wr(A_PER_LO, 8'd5);
        wr(A_PSC_HI, 8'd0);
        wr(A_PER_HI, 8'd9);
        wr(A_CTRL, 8'd0);
        settle(200);
        toggle_gap(0, "R4 low toggle interval", 18);
        toggle_gap(1, "R3 high prescaler 0 toggle interval", 10);
        pulse_gap(2, "R4 low match pulse spacing", 18);
        pulse_gap(3, "R4 high match pulse spacing", 10);

        // R2: address 7 is ignored
        wr(3'd7, 8'hFF);
        settle(40);
        toggle_gap(0, "R2 low after write to addr 7", 18);
        toggle_gap(1, "R2 high after write to addr 7", 10);

        // R10: period write waits for rollover
        gap_change(0, n);
        wr(A_PER_LO, 8'd2);
        push_exp("R10 interval in progress keeps old period", 18);
        gap_change(0, n);
        pop_cmp(n + 1);
        toggle_gap(0, "R10 new period after rollover", 9);

        // R5: high half counts events
        do_reset();
        wr(A_PER_HI, 8'd3);
        wr(A_PSC_HI, 8'd200);
        wr(A_CTRL, 8'b100);
        settle(200);
        toggle_gap(1, "R5 high half counting ev_in edges", 24);

        // R6 R7: dual PWM
        do_reset();
        wr(A_PSC_LO, 8'd1);
        wr(A_PER_LO, 8'd9);
        wr(A_DUTY_LO, 8'd3);
        wr(A_PSC_HI, 8'd0);
        wr(A_PER_HI, 8'd7);
        wr(A_DUTY_HI, 8'd0);
        wr(A_CTRL, 8'd1);
        settle(100);
        pwm_meas(0, "R6 low PWM", 6, 20);
        const_level(1, "R7 duty 0 stays low", 40, 1'b0);
        wr(A_DUTY_HI, 8'd200);
        settle(30);
        const_level(1, "R7 duty above period stays high", 40, 1'b1);
        wr(A_DUTY_HI, 8'd5);
        settle(30);
        pwm_meas(1, "R6 high PWM", 5, 8);

        // R10: duty write waits for rollover
        wait_level(0, 1'b0, n);
        wait_level(0, 1'b1, n);
        wr(A_DUTY_LO, 8'd7);
        wait_level(0, 1'b0, h);
        push_exp("R10 high time in progress keeps old duty", 6);
        pop_cmp(h + 1);
        wait_level(0, 1'b1, l);
        wait_level(0, 1'b0, h);
        push_exp("R10 new duty after rollover", 14);
        pop_cmp(h);

        // R8: chained toggle timer
        do_reset();
        wr(A_PSC_LO, 8'd1);
        wr(A_PER_LO, 8'd4);
        wr(A_PER_HI, 8'd2);
        wr(A_PSC_HI, 8'd99);
        wr(A_CTRL, 8'd2);
        settle(200);
        toggle_gap(0, "R8 low toggle in chain", 10);
        toggle_gap(1, "R8 high toggle in chain", 30);

        // R11: chained event counter
        do_reset();
        wr(A_PER_LO, 8'd1);
        wr(A_PER_HI, 8'd1);
        wr(A_CTRL, 8'b110);
        settle(200);
        toggle_gap(0, "R11 low toggle on events", 12);
        toggle_gap(1, "R11 high toggle on events", 24);

        // R9: chained timer with PWM low byte
        do_reset();
        wr(A_PSC_LO, 8'd0);
        wr(A_PER_LO, 8'd7);
        wr(A_DUTY_LO, 8'd5);
        wr(A_PER_HI, 8'd2);
        wr(A_PSC_HI, 8'd50);
        wr(A_CTRL, 8'd3);
        settle(200);
        pwm_meas(0, "R9 low PWM in chain", 5, 8);
        toggle_gap(1, "R9 high toggle in chain", 24);

        finish_run();
    end
endmodule